// File: doc/BRIEF.md
# Precomputed-Grant Matrix Arbiter with Abort

This block arbitrates among N requesters so that a grant can be issued in the same cycle its request arrives. The arbitration decision is worked out one cycle early and held in a register of per-requester enables. The live grant is then only the AND of the request vector with those held enables. While requests stay pending, the held enables name the single winner chosen by a fair matrix priority order. When nothing is pending, every enable is raised, so a lone newcomer wins at once.

If two or more requesters arrive together while every enable is raised, the grant vector has several bits set. The block flags this cycle as an abort and does not mark it valid. The held enables are then recomputed from the live requests, so a correct single grant follows one cycle later. A parameter declares an environment in which at most one request can appear per cycle. In that case the abort path is removed. Requesters are expected to hold their request until they are granted in a valid cycle.

Top module: `prearb`

## Requirements
- R1: After reset every enable is raised, and the priority order has a lower index beating a higher one. Bit i of `req`, `gnt` and the enables belongs to requester i.
- R2: `gnt` never has a bit set for a requester whose `req` bit is clear. In a cycle whose enables are one-hot, only the enabled requester can be granted.
- R3: A cycle with no pending request leaves every enable raised for the next cycle. A single request arriving then is granted in its arrival cycle.
- R4: With SAFE_ARRIVAL = 0, `abort` is high exactly in the cycles where `gnt` has more than one bit set.
- R5: `valid` is high exactly when `gnt` has exactly one bit set.
- R6: After an abort, if the requests are held, the next cycle grants exactly one requester: the one that wins under the current priority order.
- R7: After a valid grant, the winner loses priority to every other requester. If other requests remain, the winner cannot be granted in the next cycle.
- R8: If some request remains ungranted at the end of a cycle, the next cycle cannot abort.
- R9: With SAFE_ARRIVAL = 1, `abort` is never asserted, and any single-bit grant is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Request vector, one bit per requester |
| gnt | output | N | Grant vector, the live requests ANDed with the held enables |
| abort | output | 1 | Several grants were raised together in this cycle |
| valid | output | 1 | This cycle's grant is a single, correct grant |

## Verification
The bench builds two copies of the block. The first has four requesters with the abort path present. There, random arrival bursts from an idle state reach the abort-and-retry sequence, and long runs of held requests exercise the rotation of the matrix priority. The second has three requesters and the single-arrival setting. It is driven with at most one new request per cycle, which shows that grants stay valid and that the abort path is absent.

// File: rtl/prearb.sv
module prearb #(
  parameter int N            = 4,
  parameter bit SAFE_ARRIVAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         abort,
  output logic         valid
);

  logic [N-1:0]         en_q, en_d, rem, win;
  logic [N-1:0][N-1:0]  pri_q, pri_d;
  logic                 multi;

  assign gnt   = req & en_q;
  assign multi = |(gnt & (gnt - 1'b1));

  generate
    if (SAFE_ARRIVAL) begin : g_safe
      assign abort = 1'b0;
      assign valid = |gnt;
    end else begin : g_abort
      assign abort = multi;
      assign valid = (|gnt) & ~multi;
    end
  endgenerate

  always_comb begin
    pri_d = pri_q;
    if (valid) begin
      for (int i = 0; i < N; i++) begin
        if (gnt[i]) begin
          for (int j = 0; j < N; j++) begin
            if (j != i) begin
              pri_d[i][j] = 1'b0;
              pri_d[j][i] = 1'b1;
            end
          end
        end
      end
    end
  end

  assign rem = valid ? (req & ~gnt) : req;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      win[i] = rem[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && rem[j] && pri_d[j][i]) win[i] = 1'b0;
      end
    end
  end

  assign en_d = (|rem) ? win : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '1;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          pri_q[i][j] <= (i < j);
    end else begin
      en_q  <= en_d;
      pri_q <= pri_d;
    end
  end

endmodule

// File: rtl/prearb_chk.sv
module prearb_chk #(
  parameter int N            = 4,
  parameter bit SAFE_ARRIVAL = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] gnt,
  input logic         abort,
  input logic         valid
);

  p_grant_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  p_idle_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (($countones(req) != 1) || valid));

  p_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ((req != $past(req)) || valid));

  p_winner_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ((req & ~gnt) != '0)) |=> ((gnt & $past(gnt)) == '0));

  p_no_abort_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~gnt) != '0) |=> !abort);

  p_abort_excl_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort && valid));

  generate
    if (SAFE_ARRIVAL) begin : g_safe_chk
      p_safe_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !abort);
    end
  endgenerate

endmodule

bind prearb prearb_chk #(.N(N), .SAFE_ARRIVAL(SAFE_ARRIVAL)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .abort(abort), .valid(valid)
);

// File: tb/prearb_tb_top.sv
`timescale 1ns/1ps
module prearb_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] req_a = '0;
  logic [3:0] gnt_a;
  logic       abort_a, valid_a;
  logic [2:0] req_b = '0;
  logic [2:0] gnt_b;
  logic       abort_b, valid_b;

  prearb #(.N(4), .SAFE_ARRIVAL(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req_a), .gnt(gnt_a), .abort(abort_a), .valid(valid_a));

  prearb #(.N(3), .SAFE_ARRIVAL(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .req(req_b), .gnt(gnt_b), .abort(abort_b), .valid(valid_b));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]       men_a, men_b;
  logic [7:0][7:0]  mpri_a, mpri_b;
  logic [3:0]       pend_a;
  logic [2:0]       pend_b;

  function automatic logic [7:0] lane_mask(input int n);
    return 8'((16'd1 << n) - 16'd1);
  endfunction

  function automatic logic [7:0] mwin(input logic [7:0] r, input logic [7:0][7:0] p, input int n);
    logic [7:0] w;
    w = '0;
    for (int i = 0; i < n; i++) begin
      w[i] = r[i];
      for (int j = 0; j < n; j++)
        if (j != i && r[j] && p[j][i]) w[i] = 1'b0;
    end
    return w;
  endfunction

  task automatic mreset(output logic [7:0] en, output logic [7:0][7:0] pri);
    en = '1;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        pri[i][j] = (i < j);
  endtask

  task automatic mstep(input int n, input bit safe, input logic [7:0] r,
                       inout logic [7:0] en, inout logic [7:0][7:0] pri,
                       output logic [7:0] g, output logic ab, output logic v);
    logic [7:0] rem;
    int cnt;
    g   = r & en & lane_mask(n);
    cnt = $countones(g);
    ab  = !safe && (cnt > 1);
    v   = safe ? (cnt >= 1) : (cnt == 1);
    if (v) begin
      for (int i = 0; i < n; i++)
        if (g[i])
          for (int j = 0; j < n; j++)
            if (j != i) begin pri[i][j] = 1'b0; pri[j][i] = 1'b1; end
    end
    rem = v ? (r & ~g) : r;
    en  = (rem != 0) ? mwin(rem, pri, n) : lane_mask(n);
  endtask

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] ra, input logic [2:0] rb, input string tag_a, input string tag_b);
    logic [7:0] g;
    logic ab, v;
    @(negedge clk);
    req_a = ra;
    req_b = rb;
    #1;
    mstep(4, 1'b0, {4'b0, ra}, men_a, mpri_a, g, ab, v);
    chk(tag_a, "gnt_a",   {4'b0, gnt_a}, g);
    chk(tag_a, "abort_a", {7'b0, abort_a}, {7'b0, ab});
    chk(tag_a, "valid_a", {7'b0, valid_a}, {7'b0, v});
    if (v) pend_a = ra & ~g[3:0]; else pend_a = ra;
    mstep(3, 1'b1, {5'b0, rb}, men_b, mpri_b, g, ab, v);
    chk(tag_b, "gnt_b",   {5'b0, gnt_b}, g);
    chk("R9",  "abort_b", {7'b0, abort_b}, 8'h00);
    chk(tag_b, "valid_b", {7'b0, valid_b}, {7'b0, v});
    if (v) pend_b = rb & ~g[2:0]; else pend_b = rb;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] na;
    logic [2:0] nb;
    int sd;
    sd = $urandom(32'h1234_5678);
    mreset(men_a, mpri_a);
    mreset(men_b, mpri_b);
    pend_a = '0;
    pend_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, idle outputs
    cyc(4'b0000, 3'b000, "R1", "R1");
    // R3: lone arrival after idle granted at once
    cyc(4'b0100, 3'b010, "R3", "R3");
    chk("R3", "gnt_a immediate", {4'b0, gnt_a}, 8'b0000_0100);
    chk("R5", "valid_a lone", {7'b0, valid_a}, 8'h01);
    cyc(4'b0000, 3'b000, "R3", "R3");
    // R4: two simultaneous arrivals abort
    cyc(4'b0011, 3'b001, "R4", "R9");
    chk("R4", "abort_a burst", {7'b0, abort_a}, 8'h01);
    chk("R5", "valid_a burst", {7'b0, valid_a}, 8'h00);
    // R6: retry grants the higher priority requester 0
    cyc(4'b0011, 3'b000, "R6", "R9");
    chk("R6", "gnt_a retry", {4'b0, gnt_a}, 8'b0000_0001);
    // R7: requester 1 now enabled, 0 re-requesting is blocked
    cyc(4'b0011, 3'b000, "R7", "R9");
    chk("R7", "gnt_a rotate", {4'b0, gnt_a}, 8'b0000_0010);
    // R8: pending remained, new burst cannot abort
    cyc(4'b1101, 3'b000, "R8", "R9");
    chk("R8", "abort_a pending", {7'b0, abort_a}, 8'h00);
    // R2: only enabled requester may win
    cyc(4'b1100, 3'b000, "R2", "R9");
    cyc(4'b0000, 3'b000, "R3", "R3");
    // all four at once
    cyc(4'b1111, 3'b000, "R4", "R9");
    chk("R4", "abort_a all", {7'b0, abort_a}, 8'h01);
    cyc(4'b1111, 3'b000, "R6", "R9");
    chk("R6", "valid_a after all", {7'b0, valid_a}, 8'h01);

    // random phase: requests held until a valid grant
    pend_a = req_a & ~(valid_a ? gnt_a : 4'b0);
    pend_b = '0;
    for (int k = 0; k < 3000; k++) begin
      na = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) na = '0;
      nb = '0;
      if ($urandom_range(0, 2) == 0) nb = 3'(1 << $urandom_range(0, 2));
      if ((k % 500) == 499) begin na = '0; nb = '0; pend_a = '0; pend_b = '0; end
      cyc(pend_a | na, pend_b | (nb & ~pend_b), "R7", "R9");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule